// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block holds the instruction fetch address of a small 8-bit controller and the hardware stack of return addresses. The address space is 4096 words, split into four pages of 1024 words. The top two address bits form the page number. The ten bits below them are the in-page offset, and the low byte of that offset is what software sees as the PC register.

Each cycle the decoder presents one operation code, together with a 10-bit immediate, the accumulator byte and the two page-select bits from the status register. The block computes the next fetch address from these.

When an operation changes the flow of control, the block raises a bubble flag for the following cycle. That cycle is the extra instruction cycle: the operation presented during it is discarded and the address holds. The control pins are plain and level-sampled on every rising edge. There is no valid/ready handshake, because the decoder always presents exactly one operation per cycle and the block never applies back-pressure other than through the bubble flag.

Top module: `pcs_paged_pc`

## Requirements
- R1: While reset (`rst_n` low) is asserted, `pc_o` is 0xFFF, `bubble_o` is 0 and the return stack is empty.
- R2: Operation code 0 (step) advances `pc_o` by one, modulo 4096, so that 0xFFF is followed by 0x000.
- R3: Operation code 1 (jump) loads `pc_o` with {`page_sel_i`, `imm_i`}.
- R4: Operation code 2 (call) pushes `pc_o`+1 (modulo 4096) onto the stack and loads `pc_o` with {`page_sel_i`, `imm_i`}.
- R5: Operation code 3 (return) loads `pc_o` from the most recent stack entry and removes that entry.
- R6: Operation code 4 (register load) sets `pc_o` to {`page_sel_i`, 2'b00, `acc_i`}.
- R7: Operation code 5 (register add) sets `pc_o` to {`page_sel_i`, 2'b00, (`pc_o`[7:0]+`acc_i`) mod 256}.
- R8: Operation code 6 (table add) sets `pc_o` to {`page_sel_i`, `pc_o`[9:8], (`pc_o`[7:0]+`acc_i`) mod 256}. Bits 9:8 are kept unchanged.
- R9: After accepting any operation with code 1 to 6, `bubble_o` is 1 for exactly the next cycle. After accepting code 0 or code 7, `bubble_o` is 0 in the next cycle.
- R10: In a cycle where `bubble_o` is 1, the operation presented is ignored: `pc_o` holds, and the stack is not changed.
- R11: Operation code 7 (idle) leaves `pc_o` and the stack unchanged.
- R12: The stack holds 5 entries. A push onto a full stack overwrites the oldest entry.
- R13: A return on an empty stack raises no error. The stack pointer wraps circularly, so that return yields the entry in the slot below the current one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Operation code (0 step, 1 jump, 2 call, 3 return, 4 register load, 5 register add, 6 table add, 7 idle) |
| imm_i | input | 10 | In-page target for jump and call |
| acc_i | input | 8 | Accumulator byte for register load and the two add operations |
| page_sel_i | input | 2 | Page-select bits from the status register |
| pc_o | output | 12 | Current fetch address |
| bubble_o | output | 1 | High during the extra cycle that follows a flow change |

## Verification
The bench builds the block with its default parameters: a 12-bit address, a 10-bit page offset, an 8-bit accumulator and a 5-deep stack.

A stack of only five entries means that six nested calls reach the overwrite of the oldest entry. It also means that a short run of returns reaches the circular wrap on an empty stack.

Because the accumulator is 8 bits wide, random register-add and table-add operations frequently carry out of the low byte, which exercises the modulo-256 wrap. Address 0xFFF is the reset value, so a single step directly after reset covers the wrap to address zero.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    OP_STEP = 3'd0,
    OP_JUMP = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_LOAD = 3'd4,
    OP_ADD  = 3'd5,
    OP_TBL  = 3'd6,
    OP_IDLE = 3'd7
  } pcs_op_e;
endpackage

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
  parameter int WIDTH = 12,
  parameter int DEPTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] push_data,
  output logic [WIDTH-1:0] top_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0] top_q;
  logic [PTR_W-1:0] up_ptr;
  logic [PTR_W-1:0] dn_ptr;

  assign up_ptr   = (top_q == LAST) ? '0 : top_q + 1'b1;
  assign dn_ptr   = (top_q == '0) ? LAST : top_q - 1'b1;
  assign top_data = slot_q[top_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_q <= LAST;
    end else if (push) begin
      top_q <= up_ptr;
    end else if (pop) begin
      top_q <= dn_ptr;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (push && up_ptr == PTR_W'(g)) begin
        slot_q[g] <= push_data;
      end
    end
  end

  a_r12_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    top_q <= LAST);
  a_r12_push_stored: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> top_data == $past(push_data));
  a_r13_no_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
endmodule

// File: rtl/pcs_next_addr.sv
module pcs_next_addr
  import pcs_pkg::*;
#(
  parameter int PC_W   = 12,
  parameter int PAGE_W = 10,
  parameter int ACC_W  = 8
) (
  input  pcs_op_e               op,
  input  logic [PC_W-1:0]       pc,
  input  logic [PAGE_W-1:0]     imm,
  input  logic [ACC_W-1:0]      acc,
  input  logic [PC_W-PAGE_W-1:0] page_sel,
  input  logic [PC_W-1:0]       stack_top,
  output logic [PC_W-1:0]       pc_next,
  output logic [PC_W-1:0]       ret_addr,
  output logic                  push,
  output logic                  pop,
  output logic                  flow
);
  localparam int HI_W = PAGE_W - ACC_W;

  logic [ACC_W-1:0] low_sum;
  assign low_sum  = pc[ACC_W-1:0] + acc;
  assign ret_addr = pc + 1'b1;

  always_comb begin
    pc_next = pc;
    push    = 1'b0;
    pop     = 1'b0;
    flow    = 1'b1;
    unique case (op)
      OP_STEP: begin pc_next = ret_addr; flow = 1'b0; end
      OP_JUMP: pc_next = {page_sel, imm};
      OP_CALL: begin pc_next = {page_sel, imm}; push = 1'b1; end
      OP_RET:  begin pc_next = stack_top; pop = 1'b1; end
      OP_LOAD: pc_next = {page_sel, {HI_W{1'b0}}, acc};
      OP_ADD:  pc_next = {page_sel, {HI_W{1'b0}}, low_sum};
      OP_TBL:  pc_next = {page_sel, pc[PAGE_W-1:ACC_W], low_sum};
      OP_IDLE: flow = 1'b0;
      default: flow = 1'b0;
    endcase
  end
endmodule

// File: rtl/pcs_paged_pc.sv
module pcs_paged_pc
  import pcs_pkg::*;
#(
  parameter int PC_W        = 12,
  parameter int PAGE_W      = 10,
  parameter int ACC_W       = 8,
  parameter int STACK_DEPTH = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2:0]              op_i,
  input  logic [PAGE_W-1:0]       imm_i,
  input  logic [ACC_W-1:0]        acc_i,
  input  logic [PC_W-PAGE_W-1:0]  page_sel_i,
  output logic [PC_W-1:0]         pc_o,
  output logic                    bubble_o
);
  localparam logic [PC_W-1:0] RESET_VEC = '1;

  pcs_op_e         op;
  logic [PC_W-1:0] pc_q, pc_next, ret_addr, stack_top;
  logic            push, pop, flow, bubble_q, accept;

  assign op     = pcs_op_e'(op_i);
  assign accept = !bubble_q;

  pcs_next_addr #(.PC_W(PC_W), .PAGE_W(PAGE_W), .ACC_W(ACC_W)) u_next (
    .op(op), .pc(pc_q), .imm(imm_i), .acc(acc_i), .page_sel(page_sel_i),
    .stack_top(stack_top), .pc_next(pc_next), .ret_addr(ret_addr),
    .push(push), .pop(pop), .flow(flow)
  );

  pcs_ret_stack #(.WIDTH(PC_W), .DEPTH(STACK_DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(push && accept), .pop(pop && accept),
    .push_data(ret_addr), .top_data(stack_top)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q     <= RESET_VEC;
      bubble_q <= 1'b0;
    end else if (accept) begin
      pc_q     <= pc_next;
      bubble_q <= flow;
    end else begin
      bubble_q <= 1'b0;
    end
  end

  assign pc_o     = pc_q;
  assign bubble_o = bubble_q;

  a_r9_single_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_o |=> !bubble_o);
  a_r9_flow_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (!bubble_o && op_i inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6}) |=> bubble_o);
  a_r10_hold_in_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_o |=> $stable(pc_o));
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bubble_o && op_i == 3'd7) |=> ($stable(pc_o) && !bubble_o));
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!bubble_o && op_i == 3'd0) |=> pc_o == $past(pc_o) + 1'b1);
  a_r3_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (!bubble_o && op_i == 3'd1) |=> pc_o == {$past(page_sel_i), $past(imm_i)});
endmodule

// File: tb/pcs_paged_pc_tb.sv
module pcs_paged_pc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_i = 3'd7;
  logic [9:0]  imm_i = '0;
  logic [7:0]  acc_i = '0;
  logic [1:0]  page_sel_i = '0;
  logic [11:0] pc_o;
  logic        bubble_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [11:0] m_pc;
  logic        m_bub;
  logic [11:0] m_stk [5];
  int          m_top;

  always #2 clk = ~clk;

  pcs_paged_pc u_dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .imm_i(imm_i), .acc_i(acc_i),
    .page_sel_i(page_sel_i), .pc_o(pc_o), .bubble_o(bubble_o)
  );

  function automatic logic [11:0] pred_pc(input logic [2:0] op, input logic [11:0] pc,
      input logic [9:0] imm, input logic [7:0] acc, input logic [1:0] ps, input logic [11:0] top);
    logic [7:0] s;
    s = pc[7:0] + acc;
    case (op)
      3'd0: return pc + 12'd1;
      3'd1, 3'd2: return {ps, imm};
      3'd3: return top;
      3'd4: return {ps, 2'b00, acc};
      3'd5: return {ps, 2'b00, s};
      3'd6: return {ps, pc[9:8], s};
      default: return pc;
    endcase
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] op, input logic bub);
    if (bub) return "R10";
    case (op)
      3'd0: return "R2";  3'd1: return "R3";  3'd2: return "R4";
      3'd3: return "R5";  3'd4: return "R6";  3'd5: return "R7";
      3'd6: return "R8";  default: return "R11";
    endcase
  endfunction

  // Called at a negedge: drive, clock, update model, compare.
  task automatic step(input logic [2:0] op, input logic [9:0] imm,
                      input logic [7:0] acc, input logic [1:0] ps);
    string r;
    op_i = op; imm_i = imm; acc_i = acc; page_sel_i = ps;
    r = req_of(op, m_bub);
    @(posedge clk);
    if (!m_bub) begin
      logic [11:0] nx;
      nx = pred_pc(op, m_pc, imm, acc, ps, m_stk[m_top]);
      if (op == 3'd2) begin
        m_top = (m_top + 1) % 5;
        m_stk[m_top] = m_pc + 12'd1;
      end else if (op == 3'd3) begin
        m_top = (m_top + 4) % 5;
      end
      m_bub = (op >= 3'd1 && op <= 3'd6);
      m_pc = nx;
    end else begin
      m_bub = 1'b0;
    end
    @(negedge clk);
    check(r, pc_o, m_pc);
    check("R9", {11'd0, bubble_o}, {11'd0, m_bub});
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_pc = 12'hFFF; m_bub = 0; m_top = 4;
    for (int i = 0; i < 5; i++) m_stk[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", pc_o, 12'hFFF);
    check("R1", {11'd0, bubble_o}, 12'd0);
    rst_n = 1'b1;
    // R2 wrap from reset vector
    step(3'd0, 0, 0, 0);
    // R13 return on empty stack yields slot below (zero after reset)
    step(3'd3, 0, 0, 0);
    step(3'd0, 0, 0, 0);
    // R12 six nested calls overwrite the oldest
    for (int k = 0; k < 6; k++) begin
      step(3'd2, 10'(k * 37 + 5), 0, 2'(k));
      step(3'd1, 0, 0, 0);   // R10 ignored in bubble
    end
    for (int k = 0; k < 7; k++) begin
      step(3'd3, 0, 0, 0);   // R5 / R13
      step(3'd4, 0, 8'hAA, 0);
    end
    // R8 table add keeps bits 9:8 and wraps low byte
    step(3'd1, 10'h2F0, 0, 2'd3);
    step(3'd0, 0, 0, 0);
    step(3'd6, 0, 8'h20, 2'd1);
    step(3'd7, 0, 0, 0);
    // R7 register add clears bits 9:8
    step(3'd1, 10'h3F0, 0, 2'd2);
    step(3'd0, 0, 0, 0);
    step(3'd5, 0, 8'h1F, 2'd2);
    step(3'd7, 0, 0, 0);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      step(3'($urandom_range(0, 7)), 10'($urandom), 8'($urandom), 2'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule